// File: doc/BRIEF.md
# Keyboard Receive Port with Polled and Interrupt Access

This block sits between a character source (a keyboard front end that already delivers decoded 8-bit characters) and a processor bus. The source offers each character for one cycle with a strobe. The port keeps the character, sets a ready flag, and stops taking new characters until software takes the current one by reading the data register. That read clears the flag and opens the port again.

Software can work in one of two ways. It can poll the status register until the ready flag is set. It can also set an interrupt-enable bit in the status register. The port then raises an interrupt request for as long as a character waits and the enable bit is set. The bus is synchronous and word-addressed. It has an address, a read strobe, a write strobe, write data and registered read data. Read data appears on the cycle after the read strobe and shows the register contents as they were before that clock edge.

Top module: `kbd_input_port`

## Requirements
- R1: After reset the ready flag and the interrupt-enable bit are 0, `irq` is 0, `bus_rdata` is 0, and the port accepts the next strobed character.
- R2: A read at address 0xFE00 returns, one cycle later, the ready flag in bit 15 and the interrupt-enable bit in bit 14. Every other bit is 0.
- R3: A read at address 0xFE02 returns, one cycle later, the held character in bits [7:0], and bits [15:8] are 0.
- R4: A `key_stb` while the ready flag is 0 stores `key_char` and sets the ready flag at that clock edge.
- R5: A `key_stb` while the ready flag is 1 is dropped. The held character and the ready flag are unchanged.
- R6: A read of the data register clears the ready flag, so the next strobed character is accepted.
- R7: When `key_stb` and a data-register read happen in the same cycle while the flag is 1, the new character is dropped and the flag ends at 0.
- R8: A write to 0xFE00 loads bit 14 of `bus_wdata` into the interrupt-enable bit. It leaves the ready flag unchanged.
- R9: Writes to 0xFE02 change neither the held character nor the ready flag.
- R10: `irq` is 1 exactly when the ready flag and the interrupt-enable bit are both 1.
- R11: A read at any address other than 0xFE00 or 0xFE02 returns 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| key_char | input | 8 | Character offered by the source |
| key_stb | input | 1 | One-cycle strobe marking `key_char` valid |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with its default values: a 16-bit bus, 8-bit characters, the flag at bit 15 and the enable at bit 14. At these widths a random mix of character strobes, reads, writes and stray addresses often lands on the cases that matter: a strobe arriving while a character is pending, a strobe and a data read in the same cycle, and status writes that try to set bit 15. Directed sequences come first. They cover the reset values, the lockout and its release, and the collision case. A random phase of about two thousand cycles follows, checked against a reference model written in the bench.

// File: rtl/kbd_port_pkg.sv
// Package kbd_port_pkg
// Shared register-select type for the keyboard receive port.
// Assumes at most one register is addressed per cycle.
package kbd_port_pkg;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_DATA   = 2'd2
    } kbd_sel_e;

endpackage

// File: rtl/kbd_addr_decode.sv
// Module kbd_addr_decode
// Turns the bus address into a register select. An address that matches
// neither register gives SEL_NONE.
// Assumes the two register addresses differ.
module kbd_addr_decode
    import kbd_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] STATUS_ADDR = 16'hFE00,
    parameter logic [15:0] DATA_ADDR   = 16'hFE02
) (
    input  logic [ADDR_W-1:0] addr,
    output kbd_sel_e          sel
);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] DT_A = ADDR_W'(DATA_ADDR);

    // Compare the address against each register location
    always_comb begin
        if (addr == ST_A)      sel = SEL_STATUS;
        else if (addr == DT_A) sel = SEL_DATA;
        else                   sel = SEL_NONE;
    end
endmodule

// File: rtl/kbd_rx_holder.sv
// Module kbd_rx_holder
// Holds one received character and the ready flag. While the flag is set
// the port is locked and further strobes are dropped. Taking the character
// (take_i) clears the flag. A strobe gets in only while the flag is clear.
// Assumes synchronous active-low reset.
module kbd_rx_holder #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              take_i,
    output logic              ready_o,
    output logic [CHAR_W-1:0] char_o
);
    logic              ready_q;
    logic [CHAR_W-1:0] char_q;
    logic              accept;

    // A character is accepted only while no character is pending
    assign accept = stb_i && !ready_q;

    // Update the ready flag: set on accept, clear when software takes the character
    always_ff @(posedge clk) begin
        if (!rst_n)       ready_q <= 1'b0;
        else if (accept)  ready_q <= 1'b1;
        else if (take_i)  ready_q <= 1'b0;
    end

    // Store the character on accept only
    always_ff @(posedge clk) begin
        if (!rst_n)      char_q <= '0;
        else if (accept) char_q <= char_i;
    end

    assign ready_o = ready_q;
    assign char_o  = char_q;
endmodule

// File: rtl/kbd_ctrl_reg.sv
// Module kbd_ctrl_reg
// The one bus-writable status bit: interrupt enable. Loaded from the
// chosen write-data bit on each status-register write.
// Assumes synchronous active-low reset.
module kbd_ctrl_reg #(
    parameter int DATA_W = 16,
    parameter int IE_POS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ie_o
);
    logic ie_q;

    // Load the enable bit on a status write
    always_ff @(posedge clk) begin
        if (!rst_n)    ie_q <= 1'b0;
        else if (wr_i) ie_q <= wdata_i[IE_POS];
    end

    assign ie_o = ie_q;
endmodule

// File: rtl/kbd_read_mux.sv
// Module kbd_read_mux
// Builds the status and data words and registers the selected one when a
// read is strobed. Unmapped addresses read as zero. The output holds
// between reads.
// Assumes synchronous active-low reset and distinct bit positions.
module kbd_read_mux
    import kbd_port_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CHAR_W    = 8,
    parameter int READY_POS = 15,
    parameter int IE_POS    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  kbd_sel_e          sel_i,
    input  logic              ready_i,
    input  logic              ie_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] data_word;
    logic [DATA_W-1:0] rdata_q;

    // Assemble the status word; every other bit stays zero
    always_comb begin
        status_word            = '0;
        status_word[READY_POS] = ready_i;
        status_word[IE_POS]    = ie_i;
    end

    // Put the character in the low bits with zero above it
    always_comb begin
        data_word               = '0;
        data_word[CHAR_W-1:0]   = char_i;
    end

    // Register the addressed word when a read is strobed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            case (sel_i)
                SEL_STATUS: rdata_q <= status_word;
                SEL_DATA:   rdata_q <= data_word;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/kbd_input_port.sv
// Module kbd_input_port
// Memory-mapped keyboard receive port: a status register (ready flag,
// interrupt enable) and a data register on a word-addressed bus. A data
// read releases the lockout. irq follows ready AND enable.
// Assumes the source strobes for one cycle per character.
module kbd_input_port
    import kbd_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter int          CHAR_W      = 8,
    parameter int          READY_POS   = 15,
    parameter int          IE_POS      = 14,
    parameter logic [15:0] STATUS_ADDR = 16'hFE00,
    parameter logic [15:0] DATA_ADDR   = 16'hFE02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              key_stb,
    output logic              irq
);
    kbd_sel_e          sel;
    logic              rdy_q;
    logic              ie_q;
    logic [CHAR_W-1:0] char_q;
    logic              take;
    logic              st_wr;

    kbd_addr_decode #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
    ) dec_i (
        .addr(bus_addr), .sel(sel)
    );

    // A data read takes the character; a status write loads the enable
    assign take  = bus_rd && (sel == SEL_DATA);
    assign st_wr = bus_wr && (sel == SEL_STATUS);

    kbd_rx_holder #(.CHAR_W(CHAR_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .stb_i(key_stb), .char_i(key_char),
        .take_i(take), .ready_o(rdy_q), .char_o(char_q)
    );

    kbd_ctrl_reg #(.DATA_W(DATA_W), .IE_POS(IE_POS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_i(st_wr), .wdata_i(bus_wdata),
        .ie_o(ie_q)
    );

    kbd_read_mux #(
        .DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_POS(READY_POS), .IE_POS(IE_POS)
    ) rmux_i (
        .clk(clk), .rst_n(rst_n), .rd_i(bus_rd), .sel_i(sel),
        .ready_i(rdy_q), .ie_i(ie_q), .char_i(char_q), .rdata_o(bus_rdata)
    );

    // Request service while a character waits and interrupts are enabled
    assign irq = rdy_q && ie_q;
endmodule

// File: rtl/kbd_input_port_chk.sv
// Module kbd_input_port_chk
// Temporal checks on the keyboard port, attached by bind. It watches the
// bus, the source strobe and the held ready flag and character.
// Assumes the default register addresses unless overridden.
module kbd_input_port_chk #(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter int          CHAR_W      = 8,
    parameter logic [15:0] STATUS_ADDR = 16'hFE00,
    parameter logic [15:0] DATA_ADDR   = 16'hFE02
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CHAR_W-1:0] key_char,
    input logic              key_stb,
    input logic              irq,
    input logic              rdy,
    input logic [CHAR_W-1:0] ch
);
    logic data_rd;
    logic data_wr;
    assign data_rd = bus_rd && (bus_addr == ADDR_W'(DATA_ADDR));
    assign data_wr = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));

    // Accepted strobe sets the flag and stores the character
    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && key_stb) |=> (rdy && ch == $past(key_char)));

    // Strobe while pending leaves the character alone
    assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && key_stb) |=> $stable(ch));

    // Data read while pending releases the port (also covers R7)
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_rd) |=> !rdy);

    // Upper data bits read as zero
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (bus_rdata[DATA_W-1:CHAR_W] == '0));

    // Without a strobe, the flag never rises
    assert_no_bus_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_stb && !rdy) |=> !rdy);

    // Data writes leave the character unchanged
    assert_data_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !key_stb) |=> $stable(ch));

    // A rising request needs a strobe or a bus write just before
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(key_stb) || $past(bus_wr)));
endmodule

bind kbd_input_port kbd_input_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .key_char(key_char),
    .key_stb(key_stb), .irq(irq), .rdy(rdy_q), .ch(char_q)
);

// File: tb/kbd_input_port_tb.sv
// Module kbd_input_port_tb_top
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a reference model kept in the bench.
module kbd_input_port_tb_top;
    localparam logic [15:0] ST_A = 16'hFE00;
    localparam logic [15:0] DT_A = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  key_char = '0;
    logic        key_stb = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit         m_rdy = 1'b0;
    bit         m_ie = 1'b0;
    logic [7:0] m_ch = '0;
    logic [15:0] m_rdata = '0;

    always #5 clk = ~clk;

    kbd_input_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_char(key_char), .key_stb(key_stb), .irq(irq)
    );

    function automatic logic [15:0] read_value(input logic [15:0] a);
        if (a == ST_A)      return {m_rdy, m_ie, 14'b0};
        else if (a == DT_A) return {8'h00, m_ch};
        else                return 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus/source cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic step(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [15:0] wd, input bit stb, input logic [7:0] c,
                        input string req);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        key_stb = stb; key_char = c;
        @(posedge clk);
        if (rd) m_rdata = read_value(a);
        if (!m_rdy && stb) begin
            m_rdy = 1'b1; m_ch = c;
        end else if (rd && a == DT_A) begin
            m_rdy = 1'b0;
        end
        if (wr && a == ST_A) m_ie = wd[14];
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; key_stb = 1'b0;
        check({req, " rdata"}, bus_rdata, m_rdata);
        check("R10 irq", {15'b0, irq}, {15'b0, (m_rdy && m_ie)});
    endtask

    task automatic idle();
        step(16'h0000, 0, 0, 16'h0, 0, 8'h00, "idle");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
        step(ST_A, 1, 0, 0, 0, 0, "R1 status after reset");
        check("R1 status", bus_rdata, 16'h0000);
        // R4: accept first character
        step(16'h0000, 0, 0, 0, 1, 8'h41, "R4 strobe");
        step(ST_A, 1, 0, 0, 0, 0, "R2 status ready");
        check("R2 ready bit", bus_rdata, 16'h8000);
        // R5: second character dropped
        step(16'h0000, 0, 0, 0, 1, 8'h42, "R5 strobe pending");
        // R9: data write ignored
        step(DT_A, 0, 1, 16'hFFFF, 0, 0, "R9 data write");
        // R8: status write cannot clear ready, sets ie
        step(ST_A, 0, 1, 16'h4000, 0, 0, "R8 set ie");
        check("R10 irq high", {15'b0, irq}, 16'h0001);
        step(ST_A, 1, 0, 0, 0, 0, "R8 status read");
        check("R8 status", bus_rdata, 16'hC000);
        // R3/R6: data read returns first char, clears ready
        step(DT_A, 1, 0, 0, 0, 0, "R3 data read");
        check("R3 data", bus_rdata, 16'h0041);
        check("R6 irq low", {15'b0, irq}, 16'h0000);
        step(16'h0000, 0, 0, 0, 1, 8'h43, "R6 reaccept");
        // R7: collision drops new char
        step(DT_A, 1, 0, 0, 1, 8'h44, "R7 collision");
        check("R7 data", bus_rdata, 16'h0043);
        step(ST_A, 1, 0, 0, 0, 0, "R7 status");
        check("R7 status", bus_rdata, 16'h4000);
        // R8: write of bit15 does not set ready
        step(ST_A, 0, 1, 16'h8000, 0, 0, "R8 write bit15");
        step(ST_A, 1, 0, 0, 0, 0, "R8 status after");
        check("R8 ready untouched", bus_rdata, 16'h0000);
        // R11: unmapped read
        step(16'hFE04, 1, 0, 0, 0, 0, "R11 unmapped");
        check("R11 zero", bus_rdata, 16'h0000);
        idle();
        // Random phase
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] a;
            int k;
            k = int'($urandom_range(0, 3));
            a = (k == 0) ? ST_A : (k == 1) ? DT_A : (k == 2) ? 16'hFE04 : 16'($urandom());
            step(a, ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0),
                 16'($urandom()), ($urandom_range(0, 2) == 0), 8'($urandom()),
                 "R2 R3 R5 R6 R11 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule